// File: doc/BRIEF.md
# Dual-Channel Peak Gain Detector

This block measures the amplitude ratio of a network under test at one sweep frequency at a time. Two 12-bit ADC streams arrive in lockstep under one sample-valid strobe: the stimulus driven into the network and the network's response. Each code is offset binary, and its magnitude is its distance from mid-scale. The block keeps the largest magnitude of each stream over a fixed window of samples.

A sweep strobe marks each new frequency point. After the strobe the block skips a settling run of samples so that the network's transient is not measured. It then tracks both peaks over the window. A sequential restoring divider forms the response peak divided by the stimulus peak as an unsigned Q8.8 value. The result comes out on a 16-bit port with a one-cycle valid pulse.

Records appear only for points opened by the strobe. A new strobe abandons any point that is in progress.

Top module: `peak_gain_det`

## Requirements
- R1: The magnitude of a sample is |code - 2048| on 12-bit offset-binary codes. Code 0 gives 2048, and codes above mid-scale give a positive deviation of the same weight as the codes below it.
- R2: Each channel's peak is cleared when the window opens and then takes the maximum magnitude over exactly WIN valid samples (default 32). Samples after the window, including those taken while dividing, have no effect.
- R3: The first SETTLE valid samples after a sweep strobe (default 8) are ignored. A sample presented while the valid input is low is ignored at every stage.
- R4: gain equals floor(response_peak * 256 / stimulus_peak): 8 integer bits in gain[15:8] and 8 fraction bits in gain[7:0].
- R5: gain is 16'hFFFF when the stimulus peak is zero or when the quotient exceeds 16'hFFFF.
- R6: Each sweep strobe that is followed by a full settle and window yields exactly one single-cycle gain_vld pulse, and nothing is emitted without a strobe. With samples valid on every cycle from the one after the strobe, gain_vld rises SETTLE+WIN+21 clock edges after the edge that captured the strobe (61 with the defaults).
- R7: A sweep strobe arriving while a point is in progress restarts that point, and the abandoned point produces no record. A sample presented in the strobe's own cycle is not counted.
- R8: After reset, gain_vld and gain are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Sweep strobe: a new frequency point begins |
| smp_vld | input | 1 | Both sample inputs hold a new simultaneous sample |
| stim_code | input | 12 | Stimulus ADC code, offset binary |
| resp_code | input | 12 | Response ADC code, offset binary |
| gain | output | 16 | Q8.8 response/stimulus peak ratio |
| gain_vld | output | 1 | One-cycle pulse marking a new gain record |

## Verification
The hardest behaviour to expose is the boundary of the window. A peak placed on the very last window sample must count, while larger magnitudes in the settling run, in invalid cycles and during the divide must not. The bench drives full-scale codes in every excluded slot and places the stimulus peak on the final window sample, so an off-by-one in either counter shows up as a wrong quotient. Restart is reached by a second strobe in the middle of a settling run filled with full-scale samples.

// File: rtl/peak_gain_det.sv
module peak_gain_det #(
  parameter int W      = 12,
  parameter int FRAC   = 8,
  parameter int GW     = 16,
  parameter int SETTLE = 8,
  parameter int WIN    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          smp_vld,
  input  logic [W-1:0]  stim_code,
  input  logic [W-1:0]  resp_code,
  output logic [GW-1:0] gain,
  output logic          gain_vld
);
  localparam int NW   = W + FRAC;
  localparam int CM1  = (SETTLE > WIN) ? SETTLE : WIN;
  localparam int CMAX = (CM1 > NW) ? CM1 : NW;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_SET  = 3'd1;
  localparam logic [2:0] S_MEAS = 3'd2;
  localparam logic [2:0] S_LOAD = 3'd3;
  localparam logic [2:0] S_DIV  = 3'd4;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  pk_s, pk_r, mag_s, mag_r;
  logic [W-1:0]  rem, den, rem_nx;
  logic [NW-1:0] quo, quo_nx;
  logic [W:0]    trial, diff;
  logic          take, sat;

  assign mag_s = (stim_code >= MID) ? stim_code - MID : MID - stim_code;
  assign mag_r = (resp_code >= MID) ? resp_code - MID : MID - resp_code;

  assign trial  = {rem, quo[NW-1]};
  assign diff   = trial - {1'b0, den};
  assign take   = trial >= {1'b0, den};
  assign rem_nx = take ? diff[W-1:0] : trial[W-1:0];
  assign quo_nx = {quo[NW-2:0], take};
  assign sat    = (den == '0) || ((quo_nx >> GW) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      pk_s     <= '0;
      pk_r     <= '0;
      rem      <= '0;
      den      <= '0;
      quo      <= '0;
      gain     <= '0;
      gain_vld <= 1'b0;
    end else begin
      gain_vld <= 1'b0;
      if (step) begin
        st  <= S_SET;
        cnt <= '0;
      end else begin
        case (st)
          S_SET: if (smp_vld) begin
            if (cnt == CW'(SETTLE - 1)) begin
              st   <= S_MEAS;
              cnt  <= '0;
              pk_s <= '0;
              pk_r <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_MEAS: if (smp_vld) begin
            if (mag_s > pk_s) pk_s <= mag_s;
            if (mag_r > pk_r) pk_r <= mag_r;
            if (cnt == CW'(WIN - 1)) st <= S_LOAD;
            else cnt <= cnt + 1'b1;
          end
          S_LOAD: begin
            rem <= '0;
            den <= pk_s;
            quo <= {pk_r, FRAC'(0)};
            cnt <= '0;
            st  <= S_DIV;
          end
          S_DIV: begin
            rem <= rem_nx;
            quo <= quo_nx;
            if (cnt == CW'(NW - 1)) begin
              st       <= S_IDLE;
              gain_vld <= 1'b1;
              gain     <= sat ? '1 : quo_nx[GW-1:0];
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/peak_gain_det_chk.sv
module peak_gain_det_chk #(
  parameter int W  = 12,
  parameter int GW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          gain_vld,
  input logic [GW-1:0] gain,
  input logic [2:0]    st,
  input logic [W-1:0]  pk_s,
  input logic [W-1:0]  pk_r,
  input logic [W-1:0]  den
);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_vld |=> !gain_vld);

  assert_from_divide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_vld |-> $past(st) == 3'd4);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && $past(st) == 3'd0) |-> !gain_vld);

  assert_step_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !gain_vld);

  assert_peak_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 3'd1 && st == 3'd2) |-> (pk_s == '0 && pk_r == '0));

  assert_peak_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && $past(st) == 3'd2) |-> (pk_s >= $past(pk_s) && pk_r >= $past(pk_r)));

  assert_zero_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_vld && den == '0) |-> gain == '1);
endmodule

bind peak_gain_det peak_gain_det_chk #(.W(W), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .gain_vld(gain_vld), .gain(gain),
  .st(st), .pk_s(pk_s), .pk_r(pk_r), .den(den)
);

// File: tb/sim_peak_gain_det.sv
`timescale 1ns/1ps
module sim_peak_gain_det;
  localparam int SETTLE = 8;
  localparam int WIN    = 32;
  localparam int NV     = 12;
  localparam logic [11:0] MID = 12'd2048;
  // {stimulus peak, response peak, expected Q8.8 gain}
  localparam logic [39:0] VEC [NV] = '{
    {12'd1024, 12'd1024, 16'h0100}, {12'd1024, 12'd512,  16'h0080},
    {12'd1000, 12'd1500, 16'h0180}, {12'd2048, 12'd1,    16'h0000},
    {12'd3,    12'd2047, 16'hFFFF}, {12'd0,    12'd100,  16'hFFFF},
    {12'd0,    12'd0,    16'hFFFF}, {12'd2048, 12'd2048, 16'h0100},
    {12'd7,    12'd5,    16'h00B6}, {12'd255,  12'd256,  16'h0101},
    {12'd1,    12'd255,  16'hFF00}, {12'd1,    12'd256,  16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, smp_vld = 1'b0;
  logic [11:0] stim_code = MID, resp_code = MID;
  logic [15:0] gain;
  logic gain_vld;
  int checks = 0, errors = 0, pulses = 0;
  logic [15:0] got;
  bit done = 0;

  always #4 clk = ~clk;

  peak_gain_det u0 (.clk(clk), .rst_n(rst_n), .step(step), .smp_vld(smp_vld),
    .stim_code(stim_code), .resp_code(resp_code), .gain(gain), .gain_vld(gain_vld));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] code(input int mag, input bit neg);
    return neg ? 12'(2048 - mag) : 12'(2048 + mag);
  endfunction

  task automatic tick(input logic v, input logic [11:0] s, input logic [11:0] r);
    smp_vld = v; stim_code = s; resp_code = r;
    @(negedge clk);
    if (gain_vld) begin pulses++; got = gain; end
  endtask

  task automatic run_point(input int sp, input int rp, input bit gaps, input bit pos);
    pulses = 0;
    step = 1'b1;
    tick(1'b1, 12'd0, 12'd0);
    step = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      tick(1'b1, 12'd0, 12'd0);
      if (gaps) tick(1'b0, 12'd0, 12'd0);
    end
    for (int i = 0; i < WIN; i++) begin
      int ms = (i == WIN - 1) ? sp : sp / 2;
      int mr = (i == 3) ? rp : rp / 3;
      bit ng = !pos && (i % 2 == 1);
      tick(1'b1, code(ms, ng), code(mr, ng));
      if (gaps) tick(1'b0, 12'd0, 12'd0);
    end
    for (int i = 0; i < 40; i++) tick(1'b1, 12'd0, 12'd0);
    tick(1'b0, MID, MID);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R8 reset state
    chk(gain_vld == 1'b0, "R8 gain_vld after reset", gain_vld, 0);
    chk(gain == 16'h0, "R8 gain after reset", gain, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      run_point(int'(VEC[v][39:28]), int'(VEC[v][27:16]), 1'b0, 1'b0);
      chk(pulses == 1, "R6 one record per point", pulses, 1);
      chk(got == VEC[v][15:0], "R4 R5 gain table", got, VEC[v][15:0]);
    end

    // R3 invalid cycles with full-scale codes ignored
    run_point(512, 1024, 1'b1, 1'b0);
    chk(pulses == 1 && got == 16'h0200, "R3 gaps ignored", got, 16'h0200);

    // R1 positive-side deviation
    run_point(1000, 500, 1'b0, 1'b1);
    chk(pulses == 1 && got == 16'h0080, "R1 positive side magnitude", got, 16'h0080);

    // R6 no strobe, no record
    pulses = 0;
    for (int i = 0; i < 120; i++) tick(1'b1, 12'd0, 12'd4000);
    chk(pulses == 0, "R6 no output without strobe", pulses, 0);

    // R7 restart mid-settle
    pulses = 0;
    step = 1'b1; tick(1'b1, 12'd0, 12'd0); step = 1'b0;
    for (int i = 0; i < SETTLE - 2; i++) tick(1'b1, 12'd0, 12'd0);
    run_point(1024, 256, 1'b0, 1'b0);
    chk(pulses == 1, "R7 abandoned point silent", pulses, 1);
    chk(got == 16'h0040, "R7 restarted point value", got, 16'h0040);

    // R6 latency with continuous samples
    begin
      int n = 0;
      step = 1'b1; smp_vld = 1'b0;
      @(posedge clk);
      @(negedge clk);
      step = 1'b0; smp_vld = 1'b1; stim_code = code(100, 1'b1); resp_code = code(50, 1'b1);
      for (int i = 0; i < 200; i++) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (gain_vld) break;
      end
      chk(n == SETTLE + WIN + 21, "R6 latency", n, SETTLE + WIN + 21);
      chk(gain == 16'h0080, "R4 latency run value", gain, 16'h0080);
      @(negedge clk);
      chk(gain_vld == 1'b0, "R6 single-cycle pulse", gain_vld, 0);
      smp_vld = 1'b0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule